// File: doc/BRIEF.md
# Two-Ring Transmit Descriptor Gatherer

This block services two transmit descriptor rings held in system memory, an urgent ring and a regular ring. A write to either poll register starts one service pass. The pass first drains the urgent ring, if that ring is enabled and has a nonzero base. It then drains the regular ring, if its base is nonzero. Each descriptor names a data buffer. The block copies that buffer byte by byte into a local gather store, so a frame may be spread over several descriptors. When the final segment of a frame has been consumed, the assembled frame leaves as a byte stream, either on the transmit output or, in loopback mode, on a second stream that feeds the receive side.

After it consumes a descriptor, the block writes the first descriptor word back with the ownership flag cleared. It then steps that ring's index, wrapping to zero on an end-of-ring mark, and raises the completion status bits the descriptor requested. A small register port configures the block. The interrupt line is the OR of the status bits that are enabled in the mask.

Top module: `txd_fetch`

## Requirements
- R1: Descriptors are 16 bytes, at ring base + 16*index. In word 0, bit 31 = 1 means the block owns the descriptor and processes it. Reading a word 0 with bit 31 = 0 ends service of that ring and sets status bit 6.
- R2: Word 0 bits 13:0 give the segment length in bytes and word 3 gives its byte address. Bytes are taken little-endian from 32-bit memory words. The segment is appended to the gather store, and a set bit 29 (first segment) restarts the gather store at zero length.
- R3: When a descriptor with bit 28 (last segment) is consumed, the gathered bytes go out in order on out_data with out_valid, and out_last marks the final byte.
- R4: With control bit 3 (loopback) set, the finished frame leaves on lb_data/lb_valid/lb_last instead, and out_valid stays low.
- R5: When a descriptor is consumed, word 1 bit 30 sets status bit 5 and word 1 bit 31 sets status bit 4.
- R6: After consumption, word 0 is written back with bit 31 cleared and every other bit kept. The ring index becomes 0 if word 0 bit 15 (end of ring) is set, and otherwise increments.
- R7: A pass serves the urgent ring first, but only when control bit 2 is set and the urgent base is nonzero. It then serves the regular ring if the regular base is nonzero.
- R8: A poll starts a pass only when control bits 0 (transmit enable) and 1 (transmit DMA enable) are both set. Otherwise the poll is dropped, and memory, indices and status are left unchanged.
- R9: irq is high exactly when some status bit is set together with its mask bit. Writing 1s to the status register clears those bits and leaves the others.
- R10: If a segment would push the gathered length beyond BUF_BYTES, the frame is discarded: no bytes are emitted for it, status bit 7 is set, and its descriptors are still written back and stepped past.
- R11: After reset, status, mask, control, both indices, irq and all stream and memory strobes are zero.

Register map (reg_addr): 0 status (write 1 to clear), 1 mask, 2 control, 3 regular base, 4 urgent base, 5 regular poll, 6 urgent poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| irq | output | 1 | Masked interrupt |
| stat | output | 8 | Status bits |
| n_idx | output | IW | Regular ring index |
| h_idx | output | IW | Urgent ring index |
| mem_rd | output | 1 | Memory word read request |
| mem_wr | output | 1 | Memory word write request |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| out_valid | output | 1 | Transmit byte valid |
| out_data | output | 8 | Transmit byte |
| out_last | output | 1 | Final byte of frame on transmit stream |
| lb_valid | output | 1 | Loopback byte valid |
| lb_data | output | 8 | Loopback byte |
| lb_last | output | 1 | Final byte of frame on loopback stream |

## Verification
A poll is registered one edge after the register write, and the first descriptor read follows one edge later. Every memory read returns its data one cycle after the request. Each buffer byte therefore costs two cycles, and frame bytes stream out one per cycle once the last segment has been copied, so the time a result appears depends on the frame lengths. The bench does not predict absolute cycles. Its monitor compares stream bytes at the falling edge, in order, against a queue filled when the descriptors are built. Status, index and memory write-back are checked only after the bus and both streams have been idle for eight cycles, which is longer than any quiet gap inside a pass.

// File: rtl/txd_fetch.sv
module txd_fetch #(
  parameter int AW = 32,
  parameter int IW = 10,
  parameter int BUF_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          irq,
  output logic [7:0]    stat,
  output logic [IW-1:0] n_idx,
  output logic [IW-1:0] h_idx,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          lb_valid,
  output logic [7:0]    lb_data,
  output logic          lb_last
);
  localparam int LW  = $clog2(BUF_BYTES + 1);
  localparam int AIW = $clog2(BUF_BYTES);
  localparam int SW  = ((LW > 14) ? LW : 14) + 1;
  localparam logic [2:0] A_STAT = 3'd0, A_MASK = 3'd1, A_CTRL = 3'd2,
                         A_NBASE = 3'd3, A_HBASE = 3'd4, A_NPOLL = 3'd5, A_HPOLL = 3'd6;

  typedef enum logic [3:0] {S_IDLE, S_W0, S_W0R, S_W1, S_W1R, S_W3, S_W3R,
                            S_CP, S_CPR, S_FIN, S_EM, S_WB} st_t;
  st_t st;

  logic [7:0]    mask, sset;
  logic [3:0]    ctrl;
  logic [AW-1:0] nbase, hbase, bufa;
  logic          ring, pend, drop;
  logic [31:0]   w0;
  logic [1:0]    w1r;
  logic [LW-1:0] gl, ocnt;
  logic [13:0]   cnt;
  logic [7:0]    gbuf [BUF_BYTES];

  wire           wr_stat   = reg_wr && reg_addr == A_STAT;
  wire           poll      = reg_wr && (reg_addr == A_NPOLL || reg_addr == A_HPOLL);
  wire           go        = ctrl[0] && ctrl[1];
  wire           hp_ok     = ctrl[2] && hbase != '0;
  wire           n_ok      = nbase != '0;
  wire [IW-1:0]  cur_idx   = ring ? h_idx : n_idx;
  wire [AW-1:0]  desc_addr = (ring ? hbase : nbase) + (AW'(cur_idx) << 4);
  wire [AW-1:0]  byte_a    = bufa + AW'(cnt);
  wire [13:0]    dlen      = w0[13:0];
  wire [LW-1:0]  base_len  = w0[29] ? '0 : gl;
  wire           keep_drop = !w0[29] && drop;
  wire [SW-1:0]  need      = SW'(base_len) + SW'(dlen);
  wire           ovf       = need > SW'(BUF_BYTES);
  wire [7:0]     rbyte     = mem_rdata[{byte_a[1:0], 3'b000} +: 8];
  wire           em_end    = ocnt == gl - LW'(1);

  assign irq       = |(stat & mask);
  assign mem_rd    = st == S_W0 || st == S_W1 || st == S_W3 || st == S_CP;
  assign mem_wr    = st == S_WB;
  assign mem_wdata = {1'b0, w0[30:0]};
  assign out_valid = st == S_EM && !ctrl[3];
  assign lb_valid  = st == S_EM && ctrl[3];
  assign out_data  = gbuf[ocnt[AIW-1:0]];
  assign lb_data   = out_data;
  assign out_last  = out_valid && em_end;
  assign lb_last   = lb_valid && em_end;

  always_comb begin
    case (st)
      S_W1:    mem_addr = desc_addr + AW'(4);
      S_W3:    mem_addr = desc_addr + AW'(12);
      S_CP:    mem_addr = {byte_a[AW-1:2], 2'b00};
      default: mem_addr = desc_addr;
    endcase
  end

  always_comb begin
    sset = '0;
    if (st == S_W0R && !mem_rdata[31]) sset[6] = 1'b1;
    if (st == S_W3R && ovf && !keep_drop) sset[7] = 1'b1;
    if (st == S_WB) sset[5:4] = {w1r[0], w1r[1]};
  end

  always_ff @(posedge clk) begin
    if (st == S_CPR) gbuf[gl[AIW-1:0]] <= rbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; stat <= '0; mask <= '0; ctrl <= '0;
      nbase <= '0; hbase <= '0; bufa <= '0; ring <= 1'b0; pend <= 1'b0;
      drop <= 1'b0; w0 <= '0; w1r <= '0; gl <= '0; ocnt <= '0; cnt <= '0;
      n_idx <= '0; h_idx <= '0;
    end else begin
      stat <= (stat & ~(wr_stat ? reg_wdata[7:0] : 8'h00)) | sset;
      if (reg_wr) begin
        case (reg_addr)
          A_MASK:  mask  <= reg_wdata[7:0];
          A_CTRL:  ctrl  <= reg_wdata[3:0];
          A_NBASE: nbase <= reg_wdata[AW-1:0];
          A_HBASE: hbase <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
      pend <= poll || (pend && st != S_IDLE);
      case (st)
        S_IDLE:
          if (pend && go) begin
            if (hp_ok)     begin ring <= 1'b1; st <= S_W0; end
            else if (n_ok) begin ring <= 1'b0; st <= S_W0; end
          end
        S_W0:  st <= S_W0R;
        S_W0R: begin
          w0 <= mem_rdata;
          if (mem_rdata[31]) st <= S_W1;
          else if (ring && n_ok) begin ring <= 1'b0; st <= S_W0; end
          else st <= S_IDLE;
        end
        S_W1:  st <= S_W1R;
        S_W1R: begin w1r <= mem_rdata[31:30]; st <= S_W3; end
        S_W3:  st <= S_W3R;
        S_W3R: begin
          bufa <= mem_rdata;
          cnt  <= '0;
          gl   <= base_len;
          if (keep_drop || ovf) begin drop <= 1'b1; st <= S_FIN; end
          else begin drop <= 1'b0; st <= (dlen == '0) ? S_FIN : S_CP; end
        end
        S_CP:  st <= S_CPR;
        S_CPR: begin
          gl  <= gl + LW'(1);
          cnt <= cnt + 14'd1;
          st  <= (cnt + 14'd1 == dlen) ? S_FIN : S_CP;
        end
        S_FIN: begin
          ocnt <= '0;
          st   <= (w0[28] && !drop && gl != '0) ? S_EM : S_WB;
        end
        S_EM: begin
          ocnt <= ocnt + LW'(1);
          if (em_end) st <= S_WB;
        end
        S_WB: begin
          if (ring) h_idx <= w0[15] ? '0 : h_idx + IW'(1);
          else      n_idx <= w0[15] ? '0 : n_idx + IW'(1);
          st <= S_W0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module txd_fetch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] stat,
  input logic       irq,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       wb_owner,
  input logic       out_valid,
  input logic       out_last,
  input logic       lb_valid
);
  AST_MEM_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R1
  AST_WB_OWNER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> !wb_owner); // R6
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n) !(out_valid && lb_valid)); // R4
  AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) out_last |=> !out_valid); // R3
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd0) |=> ((stat & $past(stat)) == $past(stat))); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (stat == 8'h00) |-> !irq); // R9
endmodule

bind txd_fetch txd_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .stat(stat),
  .irq(irq), .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_owner(mem_wdata[31]),
  .out_valid(out_valid), .out_last(out_last), .lb_valid(lb_valid)
);

// File: tb/txd_fetch_test.sv
module txd_fetch_test;
  localparam int NB = 32'h100, HB = 32'h400;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic irq, mem_rd, mem_wr, out_valid, out_last, lb_valid, lb_last;
  logic [7:0] stat, out_data, lb_data;
  logic [9:0] n_idx, h_idx;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  txd_fetch uut (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [4096];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[13:2]];
    if (mem_wr) mem[mem_addr[13:2]] <= mem_wdata;
  end

  int tests = 0, fails = 0, ni = 0, hi = 0;
  bit exp_lb = 1'b0, done = 1'b0;
  logic [9:0] exp_q [$];
  logic [7:0] frame [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (out_valid || lb_valid)) begin
      logic [9:0] got;
      got = {lb_valid, out_valid ? out_last : lb_last, out_valid ? out_data : lb_data};
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", got, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R3/R4 stream byte {path,last,data}", got, e);
      end
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (mem_rd || mem_wr || out_valid || lb_valid) q = 0; else q++;
    end
  endtask

  task automatic poll(input bit urgent);
    wreg(urgent ? 3'd6 : 3'd5, 32'h1);
    wait_quiet();
  endtask

  function automatic int daddr(input bit hp, input int idx);
    return (hp ? HB : NB) + idx * 16;
  endfunction

  task automatic seg(input bit hp, input int len, input bit eor, input bit fts, input bit lts,
                     input bit [1:0] req, input int baddr, input int seed, input bit keep);
    int da, idx;
    logic [31:0] w;
    idx = hp ? hi : ni;
    da = daddr(hp, idx);
    w = '0; w[31] = 1'b1; w[29] = fts; w[28] = lts; w[15] = eor; w[13:0] = len[13:0];
    mem[da >> 2] = w;
    mem[(da >> 2) + 1] = {req, 30'h0};
    mem[(da >> 2) + 2] = 32'h0;
    mem[(da >> 2) + 3] = baddr;
    if (fts) frame.delete();
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      int a;
      b = 8'((seed + k * 13) & 255);
      a = baddr + k;
      mem[a >> 2][8 * (a & 3) +: 8] = b;
      frame.push_back(b);
    end
    if (lts && keep)
      for (int k = 0; k < frame.size(); k++)
        exp_q.push_back({exp_lb, k == frame.size() - 1, frame[k]});
    if (hp) hi = eor ? 0 : hi + 1; else ni = eor ? 0 : ni + 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(stat == 8'h00 && !irq, "R11 reset status/irq", {stat, irq}, 0);
    chk(n_idx == 0 && h_idx == 0, "R11 reset indices", {n_idx, h_idx}, 0);
    chk(!mem_rd && !mem_wr && !out_valid && !lb_valid, "R11 reset strobes",
        {mem_rd, mem_wr, out_valid, lb_valid}, 0);
    rst_n = 1'b1;
    wreg(3'd3, NB); wreg(3'd4, HB); wreg(3'd2, 32'h3);

    // R1 R3 R5 R6: single-segment frame, unaligned buffer
    seg(1'b0, 5, 1'b0, 1'b1, 1'b1, 2'b11, 32'h1001, 7, 1'b1);
    poll(1'b0);
    chk(stat == 8'h70, "R5 R1 status after frame", stat, 8'h70);
    chk(mem[daddr(0, 0) >> 2] == 32'h3000_0005, "R6 owner write-back", mem[daddr(0, 0) >> 2], 32'h3000_0005);
    chk(n_idx == 1, "R6 index increment", n_idx, 1);
    wreg(3'd0, 32'hff);
    chk(stat == 8'h00, "R9 clear all", stat, 0);

    // R2: three segments gathered, only bit 30 requested
    seg(1'b0, 3, 1'b0, 1'b1, 1'b0, 2'b00, 32'h1101, 20, 1'b1);
    seg(1'b0, 4, 1'b0, 1'b0, 1'b0, 2'b00, 32'h1203, 40, 1'b1);
    seg(1'b0, 2, 1'b0, 1'b0, 1'b1, 2'b01, 32'h1302, 60, 1'b1);
    poll(1'b0);
    chk(stat == 8'h60, "R5 only ok bit", stat, 8'h60);
    chk(n_idx == 4, "R6 index after three", n_idx, 4);
    wreg(3'd0, 32'hff);

    // R2: a new first segment discards an unfinished gather
    seg(1'b0, 3, 1'b0, 1'b1, 1'b0, 2'b00, 32'h1401, 80, 1'b0);
    seg(1'b0, 2, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1500, 90, 1'b1);
    poll(1'b0);
    chk(exp_q.size() == 0 && stat == 8'h40, "R2 restart gather", {exp_q.size(), stat}, 8'h40);

    // R6: end-of-ring wraps
    seg(1'b0, 1, 1'b1, 1'b1, 1'b1, 2'b00, 32'h1600, 3, 1'b1);
    poll(1'b0);
    chk(n_idx == 0, "R6 wrap to zero", n_idx, 0);

    // R7: urgent ring served first
    wreg(3'd2, 32'h7);
    seg(1'b1, 4, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1700, 111, 1'b1);
    seg(1'b0, 3, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1800, 55, 1'b1);
    poll(1'b0);
    chk(h_idx == 1 && n_idx == 1, "R7 both rings served", {h_idx, n_idx}, {10'd1, 10'd1});

    // R7: urgent ring skipped when its enable is clear
    wreg(3'd2, 32'h3);
    seg(1'b0, 2, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1900, 66, 1'b1);
    poll(1'b0);
    chk(h_idx == 1 && n_idx == 2, "R7 urgent skipped", {h_idx, n_idx}, {10'd1, 10'd2});
    seg(1'b1, 3, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1a00, 77, 1'b0);
    poll(1'b1);
    chk(mem[daddr(1, 1) >> 2][31] == 1'b1 && h_idx == 1, "R7 urgent descriptor untouched",
        mem[daddr(1, 1) >> 2][31], 1);
    for (int k = 0; k < frame.size(); k++) exp_q.push_back({1'b0, k == frame.size() - 1, frame[k]});
    wreg(3'd2, 32'h7);
    poll(1'b1);
    chk(h_idx == 2 && exp_q.size() == 0, "R7 urgent served once enabled", h_idx, 2);

    // R4: loopback
    wreg(3'd2, 32'hb);
    exp_lb = 1'b1;
    seg(1'b0, 4, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1b01, 200, 1'b1);
    poll(1'b0);
    exp_lb = 1'b0;
    chk(exp_q.size() == 0 && n_idx == 3, "R4 loopback frame delivered", exp_q.size(), 0);

    // R8: DMA enable clear, poll dropped
    wreg(3'd2, 32'h1);
    wreg(3'd0, 32'hff);
    seg(1'b0, 2, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1c00, 150, 1'b1);
    poll(1'b0);
    chk(stat == 8'h00 && n_idx == 3, "R8 no pass without enables", {stat, n_idx}, 3);
    chk(mem[daddr(0, 3) >> 2][31] == 1'b1 && exp_q.size() == 2, "R8 descriptor still owned",
        exp_q.size(), 2);
    wreg(3'd2, 32'h3);
    poll(1'b0);
    chk(exp_q.size() == 0 && n_idx == 4, "R8 pass after enabling", n_idx, 4);

    // R9: masking and selective clear
    wreg(3'd0, 32'hff);
    wreg(3'd1, 32'h20);
    seg(1'b0, 1, 1'b0, 1'b1, 1'b1, 2'b01, 32'h1d00, 9, 1'b1);
    poll(1'b0);
    chk(irq == 1'b1 && stat == 8'h60, "R9 irq on masked bit", {irq, stat}, 9'h160);
    wreg(3'd0, 32'h20);
    chk(irq == 1'b0 && stat == 8'h40, "R9 selective clear", {irq, stat}, 9'h040);
    wreg(3'd1, 32'h40);
    chk(irq == 1'b1, "R9 irq follows mask", irq, 1);
    wreg(3'd1, 32'h0);
    wreg(3'd0, 32'hff);

    // R10: oversize frame discarded, next frame fine
    seg(1'b0, 3000, 1'b0, 1'b1, 1'b1, 2'b00, 32'h2000, 1, 1'b0);
    poll(1'b0);
    chk(stat == 8'hc0, "R10 lost bit", stat, 8'hc0);
    chk(n_idx == 6 && mem[daddr(0, 5) >> 2][31] == 1'b0, "R10 descriptor consumed", n_idx, 6);
    seg(1'b0, 3, 1'b0, 1'b1, 1'b1, 2'b00, 32'h1e00, 33, 1'b1);
    poll(1'b0);
    chk(exp_q.size() == 0 && n_idx == 7, "R10 recovery frame", exp_q.size(), 0);

    chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule